// File: doc/BRIEF.md
# Memory-Stage Address Router

This block sits in the memory stage of a 32-bit pipelined processor whose bus counts 32-bit words, not bytes. For every load or store it decodes the word address and steers the access to exactly one of four targets. These are a main-memory port fronted by a data cache, a video RAM port that always answers in the same cycle, a boot ROM read port, and a slow peripheral port. If the address lies in none of these ranges, nothing is selected.

The block merges these targets behind one pipeline stall signal. The cache port has a variable latency and finishes when its done input rises. The peripheral port receives a single-cycle start pulse and holds the pipeline until its done input returns. The video RAM and ROM ports never stall. Read data is returned combinationally to writeback in the cycle the access completes.

The same unit routes instruction fetches. A fetch inside the boot ROM window reads a second ROM port directly, and any other fetch goes to the instruction cache, with its own fetch stall until that cache reports done.

Top module: `memRouter`

## Requirements
- R1: A data read with address below 1024 raises `romDataEn` with `romDataAddr` equal to the low 10 address bits and returns `romDataRdata` without stalling. A fetch below 1024 raises `romFetchEn` and returns `romFetchRdata` without stalling, and `icReq` stays low.
- R2: A fetch at address 1024 or above raises `icReq` with `icAddr` equal to the fetch address, holds `fetchStall` high while `icDone` is low, and returns `icRdata` in the cycle `icDone` is high.
- R3: A data access in [1024, 0x0100_0000) raises `dcReq` with the full address, the write data and `dcWe` equal to the write flag. `memStall` stays high while `dcDone` is low, and `dcRdata` is returned in the cycle `dcDone` is high.
- R4: A data access in [0x0200_0000, 0x0200_8000) raises `vramEn` with `vramAddr` equal to the address minus 0x0200_0000, returns `vramRdata`, and never stalls.
- R5: A data access in [0x0300_0000, 0x0300_1000) drives `ioAddr` as the address minus 0x0300_0000 and raises `ioStart`. `memStall` stays high until `ioDone` arrives in a later cycle, and `ioRdata` is returned in that cycle.
- R6: `ioStart` is high for exactly one cycle per peripheral access, however long the stall lasts, and two back-to-back peripheral accesses each receive their own pulse.
- R7: Accesses to main memory, video RAM or ROM never raise `ioStart`.
- R8: A write to an address below 1024 raises no port strobe and does not stall.
- R9: A data access to an address in no mapped range raises no port strobe, returns zero and does not stall.
- R10: While `rstN` is low, no port strobe, `memStall` or `fetchStall` is raised, even if requests are present.
- R11: At most one of `dcReq`, `vramEn`, `romDataEn`, `ioStart` is high in any cycle.
- R12: Range edges are exact. Word 1023 is ROM and 1024 is main memory. 0x00FF_FFFF is main memory and 0x0100_0000 is unmapped. The first and last words of the video RAM and peripheral windows are inside their window, and the words just outside them are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | Memory-stage access present |
| memWe | input | 1 | Access is a store |
| memAddr | input | 32 | Word address of the access |
| memWdata | input | 32 | Store data |
| memRdata | output | 32 | Load data to writeback |
| memStall | output | 1 | Hold the pipeline for the data access |
| fetchReq | input | 1 | Instruction fetch present |
| fetchAddr | input | 32 | Fetch word address |
| fetchInstr | output | 32 | Fetched instruction word |
| fetchStall | output | 1 | Hold the pipeline for the fetch |
| dcReq | output | 1 | Data cache request |
| dcWe | output | 1 | Data cache write |
| dcAddr | output | 32 | Data cache address |
| dcWdata | output | 32 | Data cache write data |
| dcRdata | input | 32 | Data cache read data |
| dcDone | input | 1 | Data cache access complete |
| vramEn | output | 1 | Video RAM enable |
| vramWe | output | 1 | Video RAM write |
| vramAddr | output | 15 | Video RAM local address |
| vramWdata | output | 32 | Video RAM write data |
| vramRdata | input | 32 | Video RAM read data |
| romDataEn | output | 1 | ROM data port read enable |
| romDataAddr | output | 10 | ROM data port address |
| romDataRdata | input | 32 | ROM data port read data |
| romFetchEn | output | 1 | ROM fetch port enable |
| romFetchAddr | output | 10 | ROM fetch port address |
| romFetchRdata | input | 32 | ROM fetch port data |
| ioStart | output | 1 | Peripheral start pulse |
| ioWe | output | 1 | Peripheral write |
| ioAddr | output | 12 | Peripheral local address |
| ioWdata | output | 32 | Peripheral write data |
| ioRdata | input | 32 | Peripheral read data |
| ioDone | input | 1 | Peripheral access complete |
| icReq | output | 1 | Instruction cache request |
| icAddr | output | 32 | Instruction cache address |
| icRdata | input | 32 | Instruction cache data |
| icDone | input | 1 | Instruction cache access complete |

## Verification
The bench works through the words on each side of every range edge, both as reads and as writes, and sweeps every ROM word for fetch. An off-by-one in the decode would send a boundary word to the wrong port, and a tag naming the strobe pattern catches this. Peripheral accesses run with several done latencies and back to back. A controller that re-armed its start while stalled would pulse `ioStart` repeatedly, and one that did not clear its busy state would swallow the second start. ROM writes and unmapped addresses are checked for silence at every port and for a zero read, so a design that stalled on them or leaked a strobe is exposed.

// File: rtl/memRouterPkg.sv
package memRouterPkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_ROM  = 3'd1,
    TGT_MAIN = 3'd2,
    TGT_VRAM = 3'd3,
    TGT_IO   = 3'd4
  } tgt_e;

  typedef struct packed {
    logic selRom;
    logic selMain;
    logic selVram;
    logic selIo;
    logic ioStart;
    logic writeEn;
    logic fetchRom;
    logic fetchCache;
  } strobes_t;

endpackage

// File: rtl/memRouterDecode.sv
module memRouterDecode
  import memRouterPkg::*;
#(
  parameter int          AW         = 32,
  parameter int unsigned ROM_WORDS  = 1024,
  parameter int unsigned MAIN_BASE  = 32'h0000_0400,
  parameter int unsigned MAIN_WORDS = 32'h00FF_FC00,
  parameter int unsigned VRAM_BASE  = 32'h0200_0000,
  parameter int unsigned VRAM_WORDS = 32'h0000_8000,
  parameter int unsigned IO_BASE    = 32'h0300_0000,
  parameter int unsigned IO_WORDS   = 32'h0000_1000
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt
);

  localparam logic [AW:0] ROM_END   = (AW+1)'(ROM_WORDS);
  localparam logic [AW:0] MAIN_LO   = (AW+1)'(MAIN_BASE);
  localparam logic [AW:0] MAIN_HI   = (AW+1)'(MAIN_BASE) + (AW+1)'(MAIN_WORDS);
  localparam logic [AW:0] VRAM_LO   = (AW+1)'(VRAM_BASE);
  localparam logic [AW:0] VRAM_HI   = (AW+1)'(VRAM_BASE) + (AW+1)'(VRAM_WORDS);
  localparam logic [AW:0] IO_LO     = (AW+1)'(IO_BASE);
  localparam logic [AW:0] IO_HI     = (AW+1)'(IO_BASE) + (AW+1)'(IO_WORDS);

  logic [AW:0] wideAddr;
  logic        inRom, inMain, inVram, inIo;

  assign wideAddr = {1'b0, addr};
  assign inRom    = wideAddr < ROM_END;
  assign inMain   = (wideAddr >= MAIN_LO) && (wideAddr < MAIN_HI);
  assign inVram   = (wideAddr >= VRAM_LO) && (wideAddr < VRAM_HI);
  assign inIo     = (wideAddr >= IO_LO) && (wideAddr < IO_HI);

  // ROM window has top priority so overlapping parameter choices stay defined.
  always_comb begin
    if (inRom)       tgt = TGT_ROM;
    else if (inMain) tgt = TGT_MAIN;
    else if (inVram) tgt = TGT_VRAM;
    else if (inIo)   tgt = TGT_IO;
    else             tgt = TGT_NONE;
  end

endmodule

// File: rtl/memRouterCtrl.sv
module memRouterCtrl
  import memRouterPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     memReq,
  input  logic     memWe,
  input  tgt_e     dataTgt,
  input  logic     fetchReq,
  input  tgt_e     fetchTgt,
  input  logic     dcDone,
  input  logic     ioDone,
  input  logic     icDone,
  output strobes_t st,
  output logic     memStall,
  output logic     fetchStall
);

  logic dataAct, fetchAct;
  logic ioBusy;
  logic ioSel;
  logic ioFinish;

  assign dataAct  = rstN && memReq;
  assign fetchAct = rstN && fetchReq;
  assign ioSel    = dataAct && (dataTgt == TGT_IO);
  // Done only counts once the start has been issued in an earlier cycle.
  assign ioFinish = ioBusy && ioDone;

  always_comb begin
    st            = '0;
    st.writeEn    = memWe;
    st.selRom     = dataAct && (dataTgt == TGT_ROM) && !memWe;
    st.selMain    = dataAct && (dataTgt == TGT_MAIN);
    st.selVram    = dataAct && (dataTgt == TGT_VRAM);
    st.selIo      = ioSel;
    st.ioStart    = ioSel && !ioBusy;
    st.fetchRom   = fetchAct && (fetchTgt == TGT_ROM);
    st.fetchCache = fetchAct && (fetchTgt != TGT_ROM);
  end

  always_comb begin
    memStall = 1'b0;
    if (st.selMain && !dcDone) memStall = 1'b1;
    if (ioSel && !ioFinish)    memStall = 1'b1;
  end

  assign fetchStall = st.fetchCache && !icDone;

  always_ff @(posedge clk) begin
    if (!rstN)                   ioBusy <= 1'b0;
    else if (st.ioStart)         ioBusy <= 1'b1;
    else if (ioFinish || !ioSel) ioBusy <= 1'b0;
  end

endmodule

// File: rtl/memRouterDp.sv
module memRouterDp
  import memRouterPkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int unsigned VRAM_BASE = 32'h0200_0000,
  parameter int unsigned IO_BASE   = 32'h0300_0000,
  parameter int          ROM_AW    = 10,
  parameter int          VRAM_AW   = 15,
  parameter int          IO_AW     = 12
) (
  input  strobes_t           st,
  input  logic [AW-1:0]      memAddr,
  input  logic [DW-1:0]      memWdata,
  output logic [DW-1:0]      memRdata,
  input  logic [AW-1:0]      fetchAddr,
  output logic [DW-1:0]      fetchInstr,
  output logic               dcReq,
  output logic               dcWe,
  output logic [AW-1:0]      dcAddr,
  output logic [DW-1:0]      dcWdata,
  input  logic [DW-1:0]      dcRdata,
  output logic               vramEn,
  output logic               vramWe,
  output logic [VRAM_AW-1:0] vramAddr,
  output logic [DW-1:0]      vramWdata,
  input  logic [DW-1:0]      vramRdata,
  output logic               romDataEn,
  output logic [ROM_AW-1:0]  romDataAddr,
  input  logic [DW-1:0]      romDataRdata,
  output logic               romFetchEn,
  output logic [ROM_AW-1:0]  romFetchAddr,
  input  logic [DW-1:0]      romFetchRdata,
  output logic               ioStart,
  output logic               ioWe,
  output logic [IO_AW-1:0]   ioAddr,
  output logic [DW-1:0]      ioWdata,
  input  logic [DW-1:0]      ioRdata,
  output logic               icReq,
  output logic [AW-1:0]      icAddr,
  input  logic [DW-1:0]      icRdata
);

  localparam logic [AW-1:0] VRAM_OFS = AW'(VRAM_BASE);
  localparam logic [AW-1:0] IO_OFS   = AW'(IO_BASE);

  // Main memory path
  assign dcReq   = st.selMain;
  assign dcWe    = st.selMain && st.writeEn;
  assign dcAddr  = memAddr;
  assign dcWdata = memWdata;

  // Video RAM path, local offset
  assign vramEn    = st.selVram;
  assign vramWe    = st.selVram && st.writeEn;
  assign vramAddr  = VRAM_AW'(memAddr - VRAM_OFS);
  assign vramWdata = memWdata;

  // ROM data read port
  assign romDataEn   = st.selRom;
  assign romDataAddr = memAddr[ROM_AW-1:0];

  // Peripheral path; address and data held for the whole stalled access
  assign ioStart = st.ioStart;
  assign ioWe    = st.selIo && st.writeEn;
  assign ioAddr  = IO_AW'(memAddr - IO_OFS);
  assign ioWdata = memWdata;

  // Fetch ports
  assign romFetchEn   = st.fetchRom;
  assign romFetchAddr = fetchAddr[ROM_AW-1:0];
  assign icReq        = st.fetchCache;
  assign icAddr       = fetchAddr;

  always_comb begin
    memRdata = '0;
    unique case (1'b1)
      st.selRom:  memRdata = romDataRdata;
      st.selMain: memRdata = dcRdata;
      st.selVram: memRdata = vramRdata;
      st.selIo:   memRdata = ioRdata;
      default:    memRdata = '0;
    endcase
  end

  always_comb begin
    if (st.fetchRom)        fetchInstr = romFetchRdata;
    else if (st.fetchCache) fetchInstr = icRdata;
    else                    fetchInstr = '0;
  end

endmodule

// File: rtl/memRouter.sv
module memRouter
  import memRouterPkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int unsigned ROM_WORDS  = 1024,
  parameter int unsigned MAIN_BASE  = 32'h0000_0400,
  parameter int unsigned MAIN_WORDS = 32'h00FF_FC00,
  parameter int unsigned VRAM_BASE  = 32'h0200_0000,
  parameter int unsigned VRAM_WORDS = 32'h0000_8000,
  parameter int unsigned IO_BASE    = 32'h0300_0000,
  parameter int unsigned IO_WORDS   = 32'h0000_1000,
  parameter int          ROM_AW     = $clog2(ROM_WORDS),
  parameter int          VRAM_AW    = $clog2(VRAM_WORDS),
  parameter int          IO_AW      = $clog2(IO_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               memReq,
  input  logic               memWe,
  input  logic [AW-1:0]      memAddr,
  input  logic [DW-1:0]      memWdata,
  output logic [DW-1:0]      memRdata,
  output logic               memStall,
  input  logic               fetchReq,
  input  logic [AW-1:0]      fetchAddr,
  output logic [DW-1:0]      fetchInstr,
  output logic               fetchStall,
  output logic               dcReq,
  output logic               dcWe,
  output logic [AW-1:0]      dcAddr,
  output logic [DW-1:0]      dcWdata,
  input  logic [DW-1:0]      dcRdata,
  input  logic               dcDone,
  output logic               vramEn,
  output logic               vramWe,
  output logic [VRAM_AW-1:0] vramAddr,
  output logic [DW-1:0]      vramWdata,
  input  logic [DW-1:0]      vramRdata,
  output logic               romDataEn,
  output logic [ROM_AW-1:0]  romDataAddr,
  input  logic [DW-1:0]      romDataRdata,
  output logic               romFetchEn,
  output logic [ROM_AW-1:0]  romFetchAddr,
  input  logic [DW-1:0]      romFetchRdata,
  output logic               ioStart,
  output logic               ioWe,
  output logic [IO_AW-1:0]   ioAddr,
  output logic [DW-1:0]      ioWdata,
  input  logic [DW-1:0]      ioRdata,
  input  logic               ioDone,
  output logic               icReq,
  output logic [AW-1:0]      icAddr,
  input  logic [DW-1:0]      icRdata,
  input  logic               icDone
);

  tgt_e     dataTgt, fetchTgt;
  strobes_t st;

  // Same decoder serves both the data and the fetch address.
  for (genvar g = 0; g < 2; g++) begin : g_dec
    tgt_e        tgtOut;
    logic [AW-1:0] decAddr;
    assign decAddr = (g == 0) ? memAddr : fetchAddr;
    memRouterDecode #(
      .AW(AW), .ROM_WORDS(ROM_WORDS),
      .MAIN_BASE(MAIN_BASE), .MAIN_WORDS(MAIN_WORDS),
      .VRAM_BASE(VRAM_BASE), .VRAM_WORDS(VRAM_WORDS),
      .IO_BASE(IO_BASE), .IO_WORDS(IO_WORDS)
    ) i_dec (
      .addr (decAddr),
      .tgt  (tgtOut)
    );
  end

  assign dataTgt  = g_dec[0].tgtOut;
  assign fetchTgt = g_dec[1].tgtOut;

  memRouterCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memReq     (memReq),
    .memWe      (memWe),
    .dataTgt    (dataTgt),
    .fetchReq   (fetchReq),
    .fetchTgt   (fetchTgt),
    .dcDone     (dcDone),
    .ioDone     (ioDone),
    .icDone     (icDone),
    .st         (st),
    .memStall   (memStall),
    .fetchStall (fetchStall)
  );

  memRouterDp #(
    .AW(AW), .DW(DW), .VRAM_BASE(VRAM_BASE), .IO_BASE(IO_BASE),
    .ROM_AW(ROM_AW), .VRAM_AW(VRAM_AW), .IO_AW(IO_AW)
  ) i_dp (
    .st            (st),
    .memAddr       (memAddr),
    .memWdata      (memWdata),
    .memRdata      (memRdata),
    .fetchAddr     (fetchAddr),
    .fetchInstr    (fetchInstr),
    .dcReq         (dcReq),
    .dcWe          (dcWe),
    .dcAddr        (dcAddr),
    .dcWdata       (dcWdata),
    .dcRdata       (dcRdata),
    .vramEn        (vramEn),
    .vramWe        (vramWe),
    .vramAddr      (vramAddr),
    .vramWdata     (vramWdata),
    .vramRdata     (vramRdata),
    .romDataEn     (romDataEn),
    .romDataAddr   (romDataAddr),
    .romDataRdata  (romDataRdata),
    .romFetchEn    (romFetchEn),
    .romFetchAddr  (romFetchAddr),
    .romFetchRdata (romFetchRdata),
    .ioStart       (ioStart),
    .ioWe          (ioWe),
    .ioAddr        (ioAddr),
    .ioWdata       (ioWdata),
    .ioRdata       (ioRdata),
    .icReq         (icReq),
    .icAddr        (icAddr),
    .icRdata       (icRdata)
  );

endmodule

// File: rtl/memRouterChk.sv
module memRouterChk #(
  parameter int          AW        = 32,
  parameter int unsigned ROM_WORDS = 1024
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memStall,
  input logic          dcReq,
  input logic          dcDone,
  input logic          vramEn,
  input logic          romDataEn,
  input logic          ioStart,
  input logic          fetchReq,
  input logic [AW-1:0] fetchAddr,
  input logic          romFetchEn,
  input logic          icReq,
  input logic          icDone,
  input logic          fetchStall
);

  localparam logic [AW:0] ROM_END = (AW+1)'(ROM_WORDS);

  logic fetchInRom;
  assign fetchInRom = fetchReq && ({1'b0, fetchAddr} < ROM_END);

  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dcReq, vramEn, romDataEn, ioStart}));

  p_single_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    ioStart |=> !ioStart);

  p_start_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    ioStart |-> memStall);

  p_vram_no_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    vramEn |-> !memStall);

  p_rom_no_wait_r1: assert property (@(posedge clk) disable iff (!rstN)
    romDataEn |-> !memStall);

  p_cache_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dcReq && !dcDone) |-> memStall);

  p_icache_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (icReq && !icDone) |-> fetchStall);

  p_rom_fetch_r1: assert property (@(posedge clk) disable iff (!rstN)
    fetchInRom |-> (romFetchEn && !icReq && !fetchStall));

  p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> !memStall);

endmodule

bind memRouter memRouterChk #(.AW(AW), .ROM_WORDS(ROM_WORDS)) i_memRouterChk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memStall   (memStall),
  .dcReq      (dcReq),
  .dcDone     (dcDone),
  .vramEn     (vramEn),
  .romDataEn  (romDataEn),
  .ioStart    (ioStart),
  .fetchReq   (fetchReq),
  .fetchAddr  (fetchAddr),
  .romFetchEn (romFetchEn),
  .icReq      (icReq),
  .icDone     (icDone),
  .fetchStall (fetchStall)
);

// File: tb/test_memRouter.sv
`timescale 1ns/1ps
module test_memRouter;

  localparam int CYC = 20;
  localparam int T_NONE = 0, T_ROM = 1, T_MAIN = 2, T_VRAM = 3, T_IO = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq = 1'b0, memWe = 1'b0;
  logic [31:0] memAddr = '0, memWdata = '0;
  logic [31:0] memRdata;
  logic        memStall;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [31:0] fetchInstr;
  logic        fetchStall;
  logic        dcReq, dcWe;
  logic [31:0] dcAddr, dcWdata, dcRdata;
  logic        dcDone = 1'b0;
  logic        vramEn, vramWe;
  logic [14:0] vramAddr;
  logic [31:0] vramWdata, vramRdata;
  logic        romDataEn;
  logic [9:0]  romDataAddr;
  logic [31:0] romDataRdata;
  logic        romFetchEn;
  logic [9:0]  romFetchAddr;
  logic [31:0] romFetchRdata;
  logic        ioStart, ioWe;
  logic [11:0] ioAddr;
  logic [31:0] ioWdata, ioRdata;
  logic        ioDone = 1'b0;
  logic        icReq;
  logic [31:0] icAddr, icRdata;
  logic        icDone = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CYC/2) clk = ~clk;

  // Responders: data derived from the address each port receives
  assign romDataRdata  = 32'hB000_0000 | 32'(romDataAddr);
  assign romFetchRdata = 32'hC300_0000 | 32'(romFetchAddr);
  assign dcRdata       = dcAddr ^ 32'h5A5A_5A5A;
  assign vramRdata     = 32'h7000_0000 | 32'(vramAddr);
  assign ioRdata       = 32'h1100_0000 | 32'(ioAddr);
  assign icRdata       = icAddr ^ 32'h0F0F_0F0F;

  memRouter i_memRouter (
    .clk(clk), .rstN(rstN),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memStall(memStall),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchInstr(fetchInstr),
    .fetchStall(fetchStall),
    .dcReq(dcReq), .dcWe(dcWe), .dcAddr(dcAddr), .dcWdata(dcWdata),
    .dcRdata(dcRdata), .dcDone(dcDone),
    .vramEn(vramEn), .vramWe(vramWe), .vramAddr(vramAddr),
    .vramWdata(vramWdata), .vramRdata(vramRdata),
    .romDataEn(romDataEn), .romDataAddr(romDataAddr), .romDataRdata(romDataRdata),
    .romFetchEn(romFetchEn), .romFetchAddr(romFetchAddr),
    .romFetchRdata(romFetchRdata),
    .ioStart(ioStart), .ioWe(ioWe), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioRdata(ioRdata), .ioDone(ioDone),
    .icReq(icReq), .icAddr(icAddr), .icRdata(icRdata), .icDone(icDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int tgtOf(input logic [31:0] a);
    if (a < 32'd1024) return T_ROM;
    if (a < 32'h0100_0000) return T_MAIN;
    if (a >= 32'h0200_0000 && a < 32'h0200_8000) return T_VRAM;
    if (a >= 32'h0300_0000 && a < 32'h0300_1000) return T_IO;
    return T_NONE;
  endfunction

  function automatic logic [31:0] strobeCode(input int t, input logic we);
    case (t)
      T_MAIN: return 32'b1000;
      T_VRAM: return 32'b0100;
      T_ROM:  return we ? 32'b0000 : 32'b0010;
      T_IO:   return 32'b0001;
      default: return 32'b0000;
    endcase
  endfunction

  function automatic logic [31:0] seenCode();
    return {28'b0, dcReq, vramEn, romDataEn, ioStart};
  endfunction

  // One data access; leaves memReq high after the completing cycle.
  task automatic dataAccess(input logic [31:0] a, input logic we, input int lat);
    int t;
    t = tgtOf(a);
    @(negedge clk);
    memReq = 1'b1; memWe = we; memAddr = a; memWdata = ~a;
    dcDone = (lat == 0); ioDone = 1'b0;
    #1;
    chk("R12 target strobes", seenCode(), strobeCode(t, we));
    case (t)
      T_ROM: begin
        if (we) begin
          chk("R8 rom write stall", 32'(memStall), 32'd0);
          chk("R8 rom write strobes", seenCode(), 32'd0);
        end else begin
          chk("R1 rom data addr", 32'(romDataAddr), a & 32'h3FF);
          chk("R1 rom data read", memRdata, 32'hB000_0000 | (a & 32'h3FF));
          chk("R1 rom no stall", 32'(memStall), 32'd0);
        end
        chk("R7 rom no start", 32'(ioStart), 32'd0);
      end
      T_MAIN: begin
        chk("R3 cache addr", dcAddr, a);
        chk("R3 cache wdata", dcWdata, ~a);
        chk("R3 cache we", 32'(dcWe), 32'(we));
        chk("R7 main no start", 32'(ioStart), 32'd0);
        for (int k = 0; k < lat; k++) begin
          chk("R3 cache stall", 32'(memStall), 32'd1);
          @(negedge clk);
          if (k == lat - 1) dcDone = 1'b1;
          #1;
        end
        chk("R3 cache done", 32'(memStall), 32'd0);
        if (!we) chk("R3 cache rdata", memRdata, a ^ 32'h5A5A_5A5A);
      end
      T_VRAM: begin
        chk("R4 vram addr", 32'(vramAddr), a - 32'h0200_0000);
        chk("R4 vram we", 32'(vramWe), 32'(we));
        chk("R4 vram no stall", 32'(memStall), 32'd0);
        chk("R7 vram no start", 32'(ioStart), 32'd0);
        if (!we) chk("R4 vram rdata", memRdata, 32'h7000_0000 | (a - 32'h0200_0000));
      end
      T_IO: begin
        chk("R5 io start", 32'(ioStart), 32'd1);
        chk("R5 io addr", 32'(ioAddr), a - 32'h0300_0000);
        chk("R5 io stall", 32'(memStall), 32'd1);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk); #1;
          chk("R6 io start once", 32'(ioStart), 32'd0);
          chk("R5 io held", 32'(memStall), 32'd1);
        end
        @(negedge clk);
        ioDone = 1'b1;
        #1;
        chk("R6 io start once at done", 32'(ioStart), 32'd0);
        chk("R5 io released", 32'(memStall), 32'd0);
        if (!we) chk("R5 io rdata", memRdata, 32'h1100_0000 | (a - 32'h0300_0000));
      end
      default: begin
        chk("R9 unmapped stall", 32'(memStall), 32'd0);
        chk("R9 unmapped strobes", seenCode(), 32'd0);
        chk("R9 unmapped rdata", memRdata, 32'd0);
      end
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    memReq = 1'b0; memWe = 1'b0; dcDone = 1'b0; ioDone = 1'b0;
    fetchReq = 1'b0; icDone = 1'b0;
  endtask

  task automatic fetchAccess(input logic [31:0] a, input int lat);
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a; icDone = (lat == 0);
    #1;
    if (a < 32'd1024) begin
      chk("R1 fetch rom en", 32'(romFetchEn), 32'd1);
      chk("R1 fetch no icache", 32'(icReq), 32'd0);
      chk("R1 fetch no stall", 32'(fetchStall), 32'd0);
      chk("R1 fetch instr", fetchInstr, 32'hC300_0000 | (a & 32'h3FF));
    end else begin
      chk("R2 icache req", 32'(icReq), 32'd1);
      chk("R2 icache addr", icAddr, a);
      for (int k = 0; k < lat; k++) begin
        chk("R2 fetch stall", 32'(fetchStall), 32'd1);
        @(negedge clk);
        if (k == lat - 1) icDone = 1'b1;
        #1;
      end
      chk("R2 fetch done", 32'(fetchStall), 32'd0);
      chk("R2 fetch instr", fetchInstr, a ^ 32'h0F0F_0F0F);
    end
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] edges [7];
    int n;
    edges[0] = 32'd0;           edges[1] = 32'd1024;
    edges[2] = 32'h0100_0000;   edges[3] = 32'h0200_0000;
    edges[4] = 32'h0200_8000;   edges[5] = 32'h0300_0000;
    edges[6] = 32'h0300_1000;

    // R10: requests present during reset
    @(negedge clk);
    memReq = 1'b1; memAddr = 32'h0300_0004; fetchReq = 1'b1; fetchAddr = 32'h800;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset strobes", seenCode(), 32'd0);
    chk("R10 reset mem stall", 32'(memStall), 32'd0);
    chk("R10 reset fetch stall", 32'(fetchStall), 32'd0);
    chk("R10 reset icache", 32'(icReq), 32'd0);
    memReq = 1'b0; fetchReq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R12 boundary sweep, reads and writes, varied latencies
    n = 0;
    for (int e = 0; e < 7; e++) begin
      for (int d = -2; d <= 2; d++) begin
        if (!(e == 0 && d < 0)) begin
          for (int w = 0; w < 2; w++) begin
            dataAccess(edges[e] + 32'(d), w[0], n % 4);
            idle();
            n++;
          end
        end
      end
    end
    dataAccess(32'hFFFF_FFFF, 1'b0, 0); idle();
    dataAccess(32'h0080_1234, 1'b0, 5); idle();
    dataAccess(32'h0300_0ABC, 1'b0, 7); idle();

    // R6: back-to-back peripheral accesses, then peripheral after main
    dataAccess(32'h0300_0010, 1'b0, 3);
    dataAccess(32'h0300_0020, 1'b1, 0);
    dataAccess(32'h0300_0030, 1'b0, 1);
    dataAccess(32'h0000_5000, 1'b0, 2);
    dataAccess(32'h0300_0040, 1'b0, 0);
    idle();

    // R1 fetch sweep over all ROM words, R2 outside
    for (int a = 0; a < 1024; a++) fetchAccess(32'(a), 0);
    idle();
    for (int a = 1024; a < 1032; a++) begin
      fetchAccess(32'(a), a % 4);
      idle();
    end
    fetchAccess(32'h0200_0000, 3); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule